// File: doc/BRIEF.md
# Periodic Ripple Subtraction Processor

This block sits after a smoothing filter and removes a low-frequency periodic ripple from the filtered stream without disturbing its DC level. Several channels share one datapath. Each input sample arrives with a strobe and a channel index. For every channel the block keeps a phase counter that wraps every L = 2^k samples. It records one ripple period of the signal into one of two waveform pages and builds the mean of that period as it goes.

Each sample is compared with the stored sample at the same phase one period earlier. A period counts as periodic when no sample in it differs from its predecessor by more than a tolerance. A periodic period that follows a complete earlier period becomes the channel's template. While a template is valid, the output is the live sample minus the template sample at the same phase plus the template mean. The ripple shape is removed and the DC level survives. With no valid template, the sample passes through unchanged.

Top module: `drip_ripple_sub`

## Requirements
- R1: After a synchronous active-low reset, `out_vld`, `out_data`, every `cap_page` bit and every `tmpl_ok` bit are 0.
- R2: Each strobed sample produces exactly one output one clock later, with `out_chan` equal to the sample's channel; `out_vld` is 0 in any cycle that follows a cycle without a strobe.
- R3: While the channel's `tmpl_ok` bit is 0 when a sample arrives, `out_data` is that sample sign-extended.
- R4: Each channel has its own phase counter that counts 0 .. 2^k-1 over that channel's samples, where k is `period_log2`. After the sample at phase 2^k-1 the counter returns to 0 and that channel's `cap_page` bit toggles. Samples are written into the page named by `cap_page` before the toggle.
- R5: A period is periodic when every sample in it satisfies |y - y_prev| <= `max_dy`, with y_prev being the same-phase sample of the other page. Equality still counts as periodic.
- R6: After the last sample of a period, `tmpl_ok` for that channel becomes 1 if the period was periodic and a full earlier period had been captured; otherwise it becomes 0. The first period after reset never sets it.
- R7: The mean of a page is the sum of its 2^k samples shifted arithmetically right by k, which rounds toward minus infinity.
- R8: While `tmpl_ok` is 1 when a sample arrives, `out_data` = y - WF + WM, computed without overflow. WF is the same-phase sample of the template page, which is the page not named by `cap_page`, and WM is that page's mean.
- R9: Channels are independent: samples on one channel never change another channel's phase, pages, template or status.
- R10: For an exactly repeating input, once the template is valid, every output equals the template mean, so the DC level is kept.
- R11: Cycles without a strobe change no state and no status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_chan | input | CW = clog2(NCH) | Channel of the sample |
| smp_data | input | DW | Filtered sample, signed |
| period_log2 | input | KW = clog2(PW+1) | k, ripple period L = 2^k (k <= PW, held stable between resets) |
| max_dy | input | DW | Periodicity tolerance, unsigned |
| out_vld | output | 1 | Output strobe |
| out_chan | output | CW | Channel of the output |
| out_data | output | DW+2 | De-rippled sample, signed |
| cap_page | output | NCH | Per channel, the page currently being written |
| tmpl_ok | output | NCH | Per channel, template valid |

## Verification
Every result is due in the clock edge that takes the sample. `out_vld`, `out_chan` and `out_data` are registered once, and `cap_page` and `tmpl_ok` update on that same edge. The bench drives a sample just after one falling edge and reads all outputs at the next falling edge. It first computes the expected output from its model's state as it stood before the sample, so it compares each sample with the status that governed it, and then the new status with the model after the update. Idle cycles are checked at the falling edge after the empty cycle, where `out_vld` must be low.

// File: rtl/drip_pkg.sv
// Shared definitions for the ripple subtraction processor.
// Assumes nothing beyond the parameters passed by the user modules.
package drip_pkg;

    // Identifies one of the two waveform pages of a channel.
    typedef enum logic {
        PAGE_A = 1'b0,
        PAGE_B = 1'b1
    } page_t;

    // Returns the other page of a pair.
    function automatic page_t other_page(input page_t p);
        return (p == PAGE_A) ? PAGE_B : PAGE_A;
    endfunction

endpackage

// File: rtl/drip_phase_ctrl.sv
// Per-channel phase counters of the ripple period.
// Each counter steps on its own channel's samples and wraps at 2^k - 1.
// Assumes k <= PW and k held stable while samples flow.
module drip_phase_ctrl #(
    parameter int NCH = 4,
    parameter int PW  = 6,
    localparam int CW = $clog2(NCH),
    localparam int KW = $clog2(PW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] chan,
    input  logic [KW-1:0] k,
    output logic [PW-1:0] cur_phase,
    output logic          at_last
);

    logic [PW-1:0] ph_q [NCH];
    logic [PW:0]   len;
    logic [PW:0]   len_m1;
    logic [PW-1:0] last_ph;

    // Derive the last phase index from the period exponent.
    always_comb begin
        len     = (PW + 1)'(1) << k;
        len_m1  = len - (PW + 1)'(1);
        last_ph = len_m1[PW-1:0];
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ph
            // Advance this channel's phase on its own samples.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ph_q[g] <= '0;
                end else if (step && chan == CW'(g)) begin
                    ph_q[g] <= (ph_q[g] == last_ph) ? '0 : ph_q[g] + PW'(1);
                end
            end
        end
    endgenerate

    // Select the phase of the channel now being served.
    always_comb begin
        cur_phase = '0;
        for (int i = 0; i < NCH; i++) begin
            if (chan == CW'(i)) cur_phase = ph_q[i];
        end
        at_last = (cur_phase == last_ph);
    end

endmodule

// File: rtl/drip_wave_mem.sv
// Waveform page storage: NCH channels x 2 pages x 2^PW samples.
// Write is synchronous; read is asynchronous so that the compare and
// the subtraction see the stored sample in the same cycle. Contents are
// not reset; a page is only read as a template after it has been filled.
module drip_wave_mem #(
    parameter int NCH = 4,
    parameter int PW  = 6,
    parameter int DW  = 16,
    localparam int CW    = $clog2(NCH),
    localparam int AW    = CW + 1 + PW,
    localparam int DEPTH = NCH * 2 * (1 << PW)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [CW-1:0]        wr_chan,
    input  logic                 wr_page,
    input  logic [PW-1:0]        wr_addr,
    input  logic signed [DW-1:0] wr_data,
    input  logic [CW-1:0]        rd_chan,
    input  logic                 rd_page,
    input  logic [PW-1:0]        rd_addr,
    output logic signed [DW-1:0] rd_data
);

    logic signed [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;

    // Form flat indices from channel, page and phase.
    always_comb begin
        wr_idx = {wr_chan, wr_page, wr_addr};
        rd_idx = {rd_chan, rd_page, rd_addr};
    end

    // Store the incoming sample into the capture page.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/drip_page_ctrl.sv
// Per-channel page bookkeeping: capture page pointer, history flag,
// periodicity flag, running sum, page means and template validity.
// Assumes at_last and the previous-period sample belong to chan.
module drip_page_ctrl
    import drip_pkg::*;
#(
    parameter int NCH = 4,
    parameter int PW  = 6,
    parameter int DW  = 16,
    localparam int CW = $clog2(NCH),
    localparam int KW = $clog2(PW + 1),
    localparam int SW = DW + PW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic [CW-1:0]        chan,
    input  logic [KW-1:0]        k,
    input  logic                 at_last,
    input  logic signed [DW-1:0] sample,
    input  logic signed [DW-1:0] prev,
    input  logic [DW-1:0]        max_dy,
    output logic [NCH-1:0]       cap_page,
    output logic [NCH-1:0]       tmpl_ok,
    output logic                 cur_cap,
    output logic                 cur_ok,
    output logic signed [DW-1:0] cur_mean
);

    logic signed [DW:0]   diff;
    logic [DW:0]          absd;
    logic                 within_tol;
    logic signed [DW-1:0] wm_q [NCH][2];

    // Test the current sample against the same phase one period earlier.
    always_comb begin
        diff       = {sample[DW-1], sample} - {prev[DW-1], prev};
        absd       = diff[DW] ? (DW + 1)'(-diff) : (DW + 1)'(diff);
        within_tol = (absd <= {1'b0, max_dy});
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic                 hit;
            page_t                cap_q;
            logic                 hist_q;
            logic                 good_q;
            logic                 ok_q;
            logic signed [SW-1:0] sum_q;
            logic signed [SW-1:0] sum_plus;
            logic signed [SW-1:0] mean_full;

            // Running sum including this sample and its floor mean.
            always_comb begin
                hit       = step && (chan == CW'(g));
                sum_plus  = sum_q + {{PW{sample[DW-1]}}, sample};
                mean_full = sum_plus >>> k;
            end

            // Update the page state of this channel on its samples.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cap_q    <= PAGE_A;
                    hist_q   <= 1'b0;
                    good_q   <= 1'b1;
                    ok_q     <= 1'b0;
                    sum_q    <= '0;
                    wm_q[g][0] <= '0;
                    wm_q[g][1] <= '0;
                end else if (hit) begin
                    if (at_last) begin
                        wm_q[g][cap_q] <= mean_full[DW-1:0];
                        ok_q   <= hist_q && good_q && within_tol;
                        hist_q <= 1'b1;
                        good_q <= 1'b1;
                        sum_q  <= '0;
                        cap_q  <= other_page(cap_q);
                    end else begin
                        good_q <= good_q && within_tol;
                        sum_q  <= sum_plus;
                    end
                end
            end

            assign cap_page[g] = cap_q;
            assign tmpl_ok[g]  = ok_q;
        end
    endgenerate

    // Select status and template mean of the channel now being served.
    always_comb begin
        cur_cap  = 1'b0;
        cur_ok   = 1'b0;
        cur_mean = '0;
        for (int i = 0; i < NCH; i++) begin
            if (chan == CW'(i)) begin
                cur_cap  = cap_page[i];
                cur_ok   = tmpl_ok[i];
                cur_mean = wm_q[i][~cap_page[i]];
            end
        end
    end

endmodule

// File: rtl/drip_ripple_sub.sv
// Top of the periodic ripple subtraction processor.
// Captures each channel's ripple period into alternating pages, tests
// periodicity against the previous period and, with a valid template,
// outputs y - WF + WM one cycle after the sample. Assumes NCH >= 2,
// period_log2 <= PW and stable between resets.
module drip_ripple_sub #(
    parameter int NCH = 4,
    parameter int PW  = 6,
    parameter int DW  = 16,
    localparam int CW = $clog2(NCH),
    localparam int KW = $clog2(PW + 1),
    localparam int OW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic [CW-1:0]        smp_chan,
    input  logic signed [DW-1:0] smp_data,
    input  logic [KW-1:0]        period_log2,
    input  logic [DW-1:0]        max_dy,
    output logic                 out_vld,
    output logic [CW-1:0]        out_chan,
    output logic signed [OW-1:0] out_data,
    output logic [NCH-1:0]       cap_page,
    output logic [NCH-1:0]       tmpl_ok
);

    logic [PW-1:0]        phase;
    logic                 at_last;
    logic signed [DW-1:0] wf;
    logic                 cur_cap;
    logic                 cur_ok;
    logic signed [DW-1:0] cur_mean;
    logic signed [OW-1:0] dr;

    drip_phase_ctrl #(.NCH(NCH), .PW(PW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (smp_vld),
        .chan      (smp_chan),
        .k         (period_log2),
        .cur_phase (phase),
        .at_last   (at_last)
    );

    drip_wave_mem #(.NCH(NCH), .PW(PW), .DW(DW)) u_mem (
        .clk     (clk),
        .wr_en   (smp_vld),
        .wr_chan (smp_chan),
        .wr_page (cur_cap),
        .wr_addr (phase),
        .wr_data (smp_data),
        .rd_chan (smp_chan),
        .rd_page (~cur_cap),
        .rd_addr (phase),
        .rd_data (wf)
    );

    drip_page_ctrl #(.NCH(NCH), .PW(PW), .DW(DW)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (smp_vld),
        .chan     (smp_chan),
        .k        (period_log2),
        .at_last  (at_last),
        .sample   (smp_data),
        .prev     (wf),
        .max_dy   (max_dy),
        .cap_page (cap_page),
        .tmpl_ok  (tmpl_ok),
        .cur_cap  (cur_cap),
        .cur_ok   (cur_ok),
        .cur_mean (cur_mean)
    );

    // Remove the mean-free template from the live sample.
    always_comb begin
        dr = {{2{smp_data[DW-1]}}, smp_data}
           - {{2{wf[DW-1]}}, wf}
           + {{2{cur_mean[DW-1]}}, cur_mean};
    end

    // Register the output sample and its channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_chan <= '0;
            out_data <= '0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) begin
                out_chan <= smp_chan;
                out_data <= cur_ok ? dr : {{2{smp_data[DW-1]}}, smp_data};
            end
        end
    end

endmodule

// File: rtl/drip_ripple_sub_chk.sv
// Property checker for drip_ripple_sub, attached with bind below.
module drip_ripple_sub_chk #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    localparam int CW = $clog2(NCH),
    localparam int OW = DW + 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smp_vld,
    input logic [CW-1:0]        smp_chan,
    input logic signed [DW-1:0] smp_data,
    input logic                 out_vld,
    input logic [CW-1:0]        out_chan,
    input logic signed [OW-1:0] out_data,
    input logic [NCH-1:0]       cap_page,
    input logic [NCH-1:0]       tmpl_ok
);

    // R2: output strobe follows the sample strobe by one cycle.
    p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(smp_vld)));

    // R2: output channel is the channel of the sample.
    p_chan_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && smp_vld) |-> (out_chan == $past(smp_chan)));

    // R3: with no valid template anywhere the sample passes unchanged.
    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && smp_vld && (tmpl_ok == '0))
        |-> (out_data == {{2{$past(smp_data[DW-1])}}, $past(smp_data)}));

    // R4: a sample toggles at most one channel's capture page.
    p_one_page_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(cap_page ^ $past(cap_page)) <= 1));

    // R11: idle cycles leave page pointers and validity alone.
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(smp_vld)) |-> ($stable(cap_page) && $stable(tmpl_ok)));

    // R6: a template only becomes valid at a period end.
    p_ok_rise_at_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((tmpl_ok & ~$past(tmpl_ok)) != '0))
        |-> (cap_page != $past(cap_page)));

endmodule

bind drip_ripple_sub drip_ripple_sub_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp_chan (smp_chan),
    .smp_data (smp_data),
    .out_vld  (out_vld),
    .out_chan (out_chan),
    .out_data (out_data),
    .cap_page (cap_page),
    .tmpl_ok  (tmpl_ok)
);

// File: tb/drip_ripple_sub_bench.sv
`timescale 1ns/1ps
module drip_ripple_sub_bench;
    localparam int NCH = 4;
    localparam int PW  = 6;
    localparam int DW  = 16;
    localparam int OW  = DW + 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_vld = 1'b0;
    logic [1:0]           smp_chan = '0;
    logic signed [DW-1:0] smp_data = '0;
    logic [2:0]           period_log2 = 3'd3;
    logic [DW-1:0]        max_dy = '0;
    logic                 out_vld;
    logic [1:0]           out_chan;
    logic signed [OW-1:0] out_data;
    logic [NCH-1:0]       cap_page;
    logic [NCH-1:0]       tmpl_ok;

    int checks = 0;
    int errors = 0;

    // Model state per channel.
    int     m_ph   [NCH];
    bit     m_cap  [NCH];
    bit     m_hist [NCH];
    bit     m_good [NCH];
    bit     m_ok   [NCH];
    longint m_sum  [NCH];
    int     m_wm   [NCH][2];
    int     m_buf  [NCH][2][64];
    int     k_cur;
    int     tol_cur;

    always #2 clk = ~clk;

    drip_ripple_sub #(.NCH(NCH), .PW(PW), .DW(DW)) u_drip_ripple_sub (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_chan(smp_chan),
        .smp_data(smp_data), .period_log2(period_log2), .max_dy(max_dy),
        .out_vld(out_vld), .out_chan(out_chan), .out_data(out_data),
        .cap_page(cap_page), .tmpl_ok(tmpl_ok)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_ph[c] = 0; m_cap[c] = 0; m_hist[c] = 0; m_good[c] = 1;
            m_ok[c] = 0; m_sum[c] = 0; m_wm[c][0] = 0; m_wm[c][1] = 0;
            for (int p = 0; p < 64; p++) begin
                m_buf[c][0][p] = 0; m_buf[c][1][p] = 0;
            end
        end
    endtask

    // Expected output of one sample per the requirements; advances the model.
    function automatic int model_step(input int c, input int y);
        int prev, res, d, ph;
        bit oth;
        ph   = m_ph[c];
        oth  = ~m_cap[c];
        prev = m_buf[c][oth][ph];
        res  = m_ok[c] ? (y - prev + m_wm[c][oth]) : y;
        d    = y - prev;
        if (d < 0) d = -d;
        m_buf[c][m_cap[c]][ph] = y;
        m_sum[c] += y;
        if (ph == (1 << k_cur) - 1) begin
            m_wm[c][m_cap[c]] = int'(m_sum[c] >>> k_cur);
            m_ok[c]   = m_hist[c] && m_good[c] && (d <= tol_cur);
            m_hist[c] = 1; m_good[c] = 1; m_sum[c] = 0;
            m_cap[c]  = ~m_cap[c]; m_ph[c] = 0;
        end else begin
            m_good[c] = m_good[c] && (d <= tol_cur);
            m_ph[c]   = ph + 1;
        end
        return res;
    endfunction

    task automatic apply_reset(input int k, input int tol);
        @(negedge clk);
        rst_n = 0; smp_vld = 0; period_log2 = 3'(k); max_dy = DW'(tol);
        repeat (3) @(negedge clk);
        rst_n = 1;
        k_cur = k; tol_cur = tol;
        model_reset();
    endtask

    // Drive one sample at a falling edge and check at the next one.
    task automatic send(input int c, input int y, output int got);
        bit pre_ok;
        int exp;
        pre_ok = m_ok[c];
        exp = model_step(c, y);
        smp_vld = 1; smp_chan = 2'(c); smp_data = DW'(y);
        @(posedge clk);
        @(negedge clk);
        smp_vld = 0;
        got = int'(out_data);
        check(out_vld && out_chan == 2'(c), "R2", "strobe/channel", out_chan, c);
        check(got == exp, pre_ok ? "R8" : "R3", "out_data", got, exp);
        check(tmpl_ok[c] == m_ok[c], "R6", "tmpl_ok", tmpl_ok[c], m_ok[c]);
        check(cap_page[c] == m_cap[c], "R4", "cap_page", cap_page[c], m_cap[c]);
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
        check(!out_vld, "R11", "out_vld idle", out_vld, 0);
    endtask

    function automatic int rip(input int p);
        return 500 + ((p * 53) % 17) * 7 - 50;
    endfunction

    initial begin
        int got;
        longint tsum;
        int tmean;
        void'($urandom(32'd20240611));

        // R1: reset state.
        apply_reset(3, 0);
        @(negedge clk);
        check(!out_vld && out_data == 0, "R1", "outputs after reset", out_data, 0);
        check(tmpl_ok == 0 && cap_page == 0, "R1", "status after reset",
              {tmpl_ok, cap_page}, 0);

        // R10 / R5: exact repetition with zero tolerance, L = 8.
        tsum = 0;
        for (int p = 0; p < 8; p++) tsum += rip(p);
        tmean = int'(tsum >>> 3);
        for (int p = 0; p < 8; p++) send(0, rip(p), got);
        check(tmpl_ok[0] == 0, "R6", "first period stays invalid", tmpl_ok[0], 0);
        check(cap_page[0] == 1, "R4", "page toggled after L samples", cap_page[0], 1);
        idle();
        for (int p = 0; p < 8; p++) send(0, rip(p), got);
        check(tmpl_ok[0] == 1, "R5", "equal periods valid at zero tolerance", tmpl_ok[0], 1);
        check(tmpl_ok[3:1] == 0, "R9", "other channels untouched", tmpl_ok[3:1], 0);
        for (int p = 0; p < 8; p++) begin
            send(0, rip(p), got);
            check(got == tmean, "R10", "DC kept", got, tmean);
        end

        // R5 boundary: diff exactly max_dy, then max_dy + 1. L = 4.
        apply_reset(2, 5);
        for (int p = 0; p < 4; p++) send(1, 100 * p, got);
        for (int p = 0; p < 4; p++) send(1, 100 * p + 5, got);
        check(tmpl_ok[1] == 1, "R5", "diff equal to tolerance is periodic", tmpl_ok[1], 1);
        for (int p = 0; p < 4; p++) send(1, 100 * p + 5 + ((p == 2) ? 6 : 0), got);
        check(tmpl_ok[1] == 0, "R5", "diff above tolerance invalidates", tmpl_ok[1], 0);
        for (int p = 0; p < 4; p++) begin
            send(1, 100 * p + 5 + ((p == 2) ? 6 : 0), got);
            check(got == 100 * p + 5 + ((p == 2) ? 6 : 0), "R3", "pass after invalid",
                  got, 100 * p + 5 + ((p == 2) ? 6 : 0));
        end

        // R7 / R8 extremes: L = 2, tolerance at full scale.
        apply_reset(1, 65535);
        send(0, 5, got); send(0, 5, got);
        send(0, -32768, got); send(0, 32767, got);
        send(0, -32768, got);
        check(got == -1, "R7", "mean of -32768,32767 floors to -1", got, -1);
        send(0, -32768, got);
        check(got == -65536, "R8", "extreme difference without overflow", got, -65536);

        // R4 with L = 1 and L = 64.
        apply_reset(0, 0);
        send(2, 7, got); send(2, 7, got); send(2, 7, got);
        check(got == 7 && tmpl_ok[2] == 1, "R4", "L=1 template", got, 7);
        apply_reset(6, 3);
        for (int i = 0; i < 192; i++) send(3, 1000 + (i % 64) * 11 + int'($urandom % 3), got);
        check(tmpl_ok[3] == 1, "R4", "L=64 template", tmpl_ok[3], 1);

        // R9 / R11: random interleave of channels with idle gaps, L = 16.
        apply_reset(4, 4);
        for (int i = 0; i < 900; i++) begin
            int c, y;
            c = int'($urandom % 4);
            if ($urandom % 5 == 0) begin
                idle();
            end else begin
                if (c == 3) y = int'($urandom % 65536) - 32768;
                else y = 300 * c - 200 + ((m_ph[c] * 29) % 13) * 15
                         + int'($urandom % 5) - 2;
                send(c, y, got);
            end
        end
        check(tmpl_ok[0] == 1 && tmpl_ok[1] == 1, "R9", "rippled channels valid",
              tmpl_ok[1:0], 3);
        check(tmpl_ok[3] == 0, "R9", "random channel invalid", tmpl_ok[3], 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule